// File: doc/BRIEF.md
# Power Switch Control Register Bank with Delayed Readback

This block is the serial control register bank of a four-channel high-side power switch controller. A host talks to it over a 16-bit SPI frame. Each accepted frame writes one register: a bank of global bits, or one of three per-channel configuration nibbles. At the same time the block shifts out a response word. That word carries the global supply flags, the address of the previous accepted command, one summary status bit per channel, and a 4-bit data field. The data field shows the register that the previous command addressed.

The block also keeps the latched fault nibble of each channel. A fault flag sets its bit. A new switch-on request clears the channel's bits. That request is either an SPI write of a one to the channel's switch-on bit or a rising edge on the channel's direct input pin. The SPI pins are assumed to be already synchronous to `clk`, which runs several times faster than SCLK. The block detects the pin edges by oversampling them.

Inbound frame layout: bit 15 is a watchdog toggle bit. Bits 14:13 are the channel select `sel`. Bits 12:10 are the register code. Bits 9:4 are ignored. Bits 3:0 are the data. The 5-bit address is bits 14:10.

Top module: `swbank_top`

## Requirements
- R1: The response word is {wd toggle bit of the last accepted frame [15], undervoltage flag [14], overvoltage flag [13], previous address [12:8], status [7:4], data [3:0]}. Status bit 4+n is the OR of channel n's latched fault nibble.
- R2: The previous-address field holds bits 14:10 of the last accepted frame. It is 00000 after reset and changes only when a frame is accepted.
- R3: A frame is accepted when CS_n rises after exactly 16 SCLK rising edges. Frames of any other length change no register, no fault bit and no previous address.
- R4: Code 000 returns the latched fault nibble of channel `sel`: bit 3 overtemperature, bit 2 overcurrent-high, bit 1 overcurrent-low, bit 0 open-load.
- R5: Code 001 with sel[0]=0 writes and reads the switch-on bits. Code 001 with sel[0]=1 writes and reads the current-sense enables. Data bit n belongs to channel n, and sel[1] is ignored.
- R6: Codes 010 (overcurrent settings), 011 (diagnostic settings) and 100 (drive settings) each hold a separate 4-bit nibble per channel. A write to one channel leaves the others unchanged, and a read returns the nibble of channel `sel`.
- R7: Code 101 with sel[0]=0 writes data[1:0] as {undervoltage disable, overvoltage disable}. It reads back as {00, those two bits}.
- R8: Code 101 with sel[0]=1 writes data[1:0] as the watchdog period. It reads back as {0, watchdog timeout input, period}.
- R9: Code 110 with sel[0]=0 reads {channel 2 strap, channel 0 strap, watchdog enable, wake pin}. Code 110 with sel[0]=1 reads the live direct input pins. Code 111 reads 0000. Codes 000, 110 and 111 write nothing.
- R10: A high fault flag sets its latched bit. A channel's bits are cleared by an accepted code-001, sel[0]=0 frame whose data bit for that channel is 1, or by a rising edge of that channel's direct pin. A flag that is still high wins over a clear.
- R11: SO is enabled only while CS_n is low. The response is loaded at the falling edge of CS_n and sent MSB first, advancing after each SCLK falling edge. MOSI is sampled on SCLK rising edges.
- R12: After reset, every configuration output, the toggle bit and all fault bits are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the SPI pins |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sclk_i | input | 1 | SPI serial clock |
| spi_cs_n_i | input | 1 | SPI chip select, active low |
| spi_mosi_i | input | 1 | Serial data in |
| spi_miso_o | output | 1 | Serial data out |
| spi_miso_oe_o | output | 1 | Output enable for the SO pad |
| flt_otemp_i | input | 4 | Overtemperature flag per channel |
| flt_ochi_i | input | 4 | Overcurrent-high flag per channel |
| flt_oclo_i | input | 4 | Overcurrent-low flag per channel |
| flt_oload_i | input | 4 | Open-load flag per channel |
| din_i | input | 4 | Direct input pin levels |
| wake_i | input | 1 | Wake pin level |
| wd_timeout_i | input | 1 | Watchdog has timed out (fail-safe) |
| wd_en_i | input | 1 | Watchdog is enabled |
| strap_ch2_i | input | 1 | Fail-safe strap state of channel 2 |
| strap_ch0_i | input | 1 | Fail-safe strap state of channel 0 |
| uv_flag_i | input | 1 | Undervoltage flag |
| ov_flag_i | input | 1 | Overvoltage flag |
| ch_on_o | output | 4 | SPI switch-on bits |
| sense_en_o | output | 4 | Current-sense enables |
| ocur_cfg_o | output | 16 | Overcurrent nibble per channel, channel n at [4n+3:4n] |
| diag_cfg_o | output | 16 | Diagnostic nibble per channel |
| drive_cfg_o | output | 16 | Drive nibble per channel |
| uvov_dis_o | output | 2 | {undervoltage disable, overvoltage disable} |
| wd_period_o | output | 2 | Watchdog period |

## Verification
The bench keeps a model of every register and predicts each full response word, so it catches a data field that shows the current command instead of the previous one. It runs chains of writes where each frame reads back its predecessor. These chains expose a design that lets sel[1] split the global registers, or that mixes up the channel nibbles, because the wrong channel or stale data would come back. Frames of 8 and 17 clocks check that a design counting only "at least 16" or committing on any CS_n rise gets caught: the switch-on port and the echoed address would change. Fault tests clear one channel over SPI and another by a pin edge. A design that clears every channel, or misses the pin edge, leaves a wrong status nibble in the next response.

// File: rtl/swbank_pkg.sv
// Package: shared sizes, register codes and the per-channel config type
// of the switch control register bank. All modules import it.
package swbank_pkg;
    localparam int FRAME_W = 16;              // bits per SPI frame
    localparam int NCH     = 4;               // switch channels
    localparam int SEL_W   = $clog2(NCH);     // channel select width
    localparam int CODE_W  = 3;               // register code width
    localparam int NIB_W   = 4;               // readback data width
    localparam int ADDR_W  = SEL_W + CODE_W;  // full address width
    localparam int ADDR_LO = FRAME_W - 1 - ADDR_W; // lowest address bit in a frame

    // Register codes (low three address bits)
    typedef enum logic [CODE_W-1:0] {
        RC_FAULT = 3'd0,   // per channel fault nibble, read only
        RC_CHSET = 3'd1,   // switch-on bits / sense enables
        RC_OCUR  = 3'd2,   // per channel overcurrent settings
        RC_DIAG  = 3'd3,   // per channel diagnostic settings
        RC_DRIVE = 3'd4,   // per channel drive settings
        RC_GLOB  = 3'd5,   // supply disables / watchdog period
        RC_PINS  = 3'd6,   // strap, wake and direct pin status, read only
        RC_NONE  = 3'd7    // reads zero
    } regcode_e;

    // Per-channel configuration; nibble bit order is what reads back
    typedef struct packed {
        logic [NIB_W-1:0] ocur;   // {ocur_hi_sel, ocur_lo_lvl[2:0]}
        logic [NIB_W-1:0] diag;   // {oload_dis, oclo_dis, oc_timer[1:0]}
        logic [NIB_W-1:0] drive;  // {fast_slew, hi_sense_rng, din_dis, and_or}
    } chcfg_t;
endpackage

// File: rtl/swbank_shifter.sv
// swbank_shifter: oversampled SPI slave frame engine.
// Assumes SCLK, CS_n and MOSI are synchronous to clk and each SCLK
// phase lasts at least two clk cycles. Loads resp_i at CS_n fall,
// shifts MSB first, and pulses commit_o when CS_n rises after exactly
// FRAME_W SCLK rising edges.
module swbank_shifter
    import swbank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_i,
    input  logic              cs_n_i,
    input  logic              mosi_i,
    input  logic [FRAME_W-1:0] resp_i,
    output logic              miso_o,
    output logic              oe_o,
    output logic              commit_o,
    output logic              wd_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [NIB_W-1:0]  data_o
);
    localparam int CNT_W = $clog2(FRAME_W + 2);
    localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(FRAME_W + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);

    logic               cs_q, sclk_q;
    logic [FRAME_W-1:0] rx_q, tx_q;
    logic [CNT_W-1:0]   cnt_q;
    logic               cs_fall, cs_rise, sclk_rise, sclk_fall;

    // Edge detection against the previous samples
    assign cs_fall   = cs_q & ~cs_n_i;
    assign cs_rise   = ~cs_q & cs_n_i;
    assign sclk_rise = ~cs_n_i & sclk_i & ~sclk_q;
    assign sclk_fall = ~cs_n_i & ~sclk_i & sclk_q;

    // Pin history, shift registers and the saturating edge counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_q   <= 1'b1;
            sclk_q <= 1'b0;
            rx_q   <= '0;
            tx_q   <= '0;
            cnt_q  <= '0;
        end else begin
            cs_q   <= cs_n_i;
            sclk_q <= sclk_i;
            if (cs_fall) begin
                tx_q  <= resp_i;
                cnt_q <= '0;
            end else begin
                if (sclk_rise) begin
                    rx_q <= {rx_q[FRAME_W-2:0], mosi_i};
                    if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
                end
                if (sclk_fall) tx_q <= {tx_q[FRAME_W-2:0], 1'b0};
            end
        end
    end

    // Outputs: serial bit, pad enable and the decoded frame fields
    assign miso_o   = tx_q[FRAME_W-1];
    assign oe_o     = ~cs_n_i;
    assign commit_o = cs_rise & (cnt_q == CNT_FULL);
    assign wd_o     = rx_q[FRAME_W-1];
    assign addr_o   = rx_q[FRAME_W-2 -: ADDR_W];
    assign data_o   = rx_q[NIB_W-1:0];

    // R11: the response is captured at the CS_n falling edge
    a_r11_load_at_cs_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_q && !cs_n_i) |=> (tx_q == $past(resp_i)));
    // R11: the outgoing word only moves on an SCLK fall or a new load
    a_r11_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!(cs_q && !cs_n_i) && !(sclk_q && !sclk_i)) |=> $stable(tx_q));
    // R3: an accepted frame yields a single commit pulse
    a_r3_single_commit: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |=> !commit_o);
endmodule

// File: rtl/swbank_regs.sv
// swbank_regs: configuration registers and the readback data mux.
// Assumes commit_i is a single-cycle pulse. Writes decode sel and code
// from addr_i; reads decode rd_addr_i (the previous address).
module swbank_regs
    import swbank_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       commit_i,
    input  logic [ADDR_W-1:0]          addr_i,
    input  logic [NIB_W-1:0]           data_i,
    input  logic [ADDR_W-1:0]          rd_addr_i,
    input  logic [NCH-1:0][NIB_W-1:0]  flt_i,
    input  logic                       wd_timeout_i,
    input  logic                       wd_en_i,
    input  logic                       strap_ch2_i,
    input  logic                       strap_ch0_i,
    input  logic                       wake_i,
    input  logic [NCH-1:0]             din_i,
    output logic [NCH-1:0]             on_o,
    output logic [NCH-1:0]             sen_o,
    output chcfg_t [NCH-1:0]           cfg_o,
    output logic [1:0]                 uvov_o,
    output logic [1:0]                 wdper_o,
    output logic [NCH-1:0]             on_set_o,
    output logic [NIB_W-1:0]           rd_data_o
);
    logic [SEL_W-1:0] wsel, rsel;
    regcode_e         wcode, rcode;
    logic [NCH-1:0]   on_q, sen_q;
    chcfg_t [NCH-1:0] cfg_q;
    logic [1:0]       uvov_q, wdper_q;

    assign wsel  = addr_i[ADDR_W-1 -: SEL_W];
    assign wcode = regcode_e'(addr_i[CODE_W-1:0]);
    assign rsel  = rd_addr_i[ADDR_W-1 -: SEL_W];
    assign rcode = regcode_e'(rd_addr_i[CODE_W-1:0]);

    // Register writes on an accepted frame
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            on_q    <= '0;
            sen_q   <= '0;
            cfg_q   <= '0;
            uvov_q  <= '0;
            wdper_q <= '0;
        end else if (commit_i) begin
            case (wcode)
                RC_CHSET: if (wsel[0]) sen_q <= data_i; else on_q <= data_i;
                RC_OCUR:  cfg_q[wsel].ocur  <= data_i;
                RC_DIAG:  cfg_q[wsel].diag  <= data_i;
                RC_DRIVE: cfg_q[wsel].drive <= data_i;
                RC_GLOB:  if (wsel[0]) wdper_q <= data_i[1:0]; else uvov_q <= data_i[1:0];
                default:  ;
            endcase
        end
    end

    // Switch-on request pulses used to clear latched faults
    always_comb begin
        on_set_o = '0;
        if (commit_i && wcode == RC_CHSET && !wsel[0]) on_set_o = data_i;
    end

    // Readback mux for the previous address
    always_comb begin
        case (rcode)
            RC_FAULT: rd_data_o = flt_i[rsel];
            RC_CHSET: rd_data_o = rsel[0] ? sen_q : on_q;
            RC_OCUR:  rd_data_o = cfg_q[rsel].ocur;
            RC_DIAG:  rd_data_o = cfg_q[rsel].diag;
            RC_DRIVE: rd_data_o = cfg_q[rsel].drive;
            RC_GLOB:  rd_data_o = rsel[0] ? {1'b0, wd_timeout_i, wdper_q} : {2'b00, uvov_q};
            RC_PINS:  rd_data_o = rsel[0] ? din_i : {strap_ch2_i, strap_ch0_i, wd_en_i, wake_i};
            default:  rd_data_o = '0;
        endcase
    end

    assign on_o    = on_q;
    assign sen_o   = sen_q;
    assign cfg_o   = cfg_q;
    assign uvov_o  = uvov_q;
    assign wdper_o = wdper_q;

    // R9: read-only codes leave every register untouched
    a_r9_readonly_codes: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_i && (wcode == RC_FAULT || wcode == RC_PINS || wcode == RC_NONE))
        |=> ($stable(on_q) && $stable(sen_q) && $stable(cfg_q) && $stable(uvov_q) && $stable(wdper_q)));
    // R5: a sense-enable write keeps the switch-on bits
    a_r5_sense_keeps_on: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_i && wcode == RC_CHSET && wsel[0]) |=> $stable(on_q));
    // R3: without a commit no register changes
    a_r3_no_commit_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_i |=> ($stable(on_q) && $stable(sen_q) && $stable(cfg_q)));
endmodule

// File: rtl/swbank_faults.sv
// swbank_faults: per-channel sticky fault nibbles.
// Assumes flag and pin inputs are synchronous to clk. A channel clears
// on an SPI switch-on pulse or a rising edge of its direct pin; a flag
// that is high in the same cycle wins.
module swbank_faults
    import swbank_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NCH-1:0]            ot_i,
    input  logic [NCH-1:0]            oh_i,
    input  logic [NCH-1:0]            ol_i,
    input  logic [NCH-1:0]            op_i,
    input  logic [NCH-1:0]            on_set_i,
    input  logic [NCH-1:0]            din_i,
    output logic [NCH-1:0][NIB_W-1:0] flt_o
);
    logic [NCH-1:0] din_q;

    // Direct pin history for rising edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) din_q <= '0;
        else        din_q <= din_i;
    end

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        logic [NIB_W-1:0] set_v, lat_q;
        logic             clr;

        assign set_v = {ot_i[ch], oh_i[ch], ol_i[ch], op_i[ch]};
        assign clr   = on_set_i[ch] | (din_i[ch] & ~din_q[ch]);

        // Sticky set, cleared by a switch-on request
        always_ff @(posedge clk) begin
            if (!rst_n) lat_q <= '0;
            else        lat_q <= (lat_q & ~{NIB_W{clr}}) | set_v;
        end
        assign flt_o[ch] = lat_q;

        // R10: a raised flag is latched in the next cycle
        a_r10_flag_latches: assert property (@(posedge clk) disable iff (!rst_n)
            (set_v != '0) |=> ((lat_q & $past(set_v)) == $past(set_v)));
        // R10: a latched bit only drops after a switch-on request
        a_r10_drop_needs_clear: assert property (@(posedge clk) disable iff (!rst_n)
            (($past(lat_q) & ~lat_q) != '0) |-> $past(clr));
    end
endmodule

// File: rtl/swbank_top.sv
// swbank_top: switch control register bank with delayed readback.
// Holds the previous accepted address and watchdog toggle bit, and
// assembles the response word shifted out on the next frame.
module swbank_top
    import swbank_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               spi_sclk_i,
    input  logic               spi_cs_n_i,
    input  logic               spi_mosi_i,
    output logic               spi_miso_o,
    output logic               spi_miso_oe_o,
    input  logic [NCH-1:0]     flt_otemp_i,
    input  logic [NCH-1:0]     flt_ochi_i,
    input  logic [NCH-1:0]     flt_oclo_i,
    input  logic [NCH-1:0]     flt_oload_i,
    input  logic [NCH-1:0]     din_i,
    input  logic               wake_i,
    input  logic               wd_timeout_i,
    input  logic               wd_en_i,
    input  logic               strap_ch2_i,
    input  logic               strap_ch0_i,
    input  logic               uv_flag_i,
    input  logic               ov_flag_i,
    output logic [NCH-1:0]     ch_on_o,
    output logic [NCH-1:0]     sense_en_o,
    output logic [NCH*NIB_W-1:0] ocur_cfg_o,
    output logic [NCH*NIB_W-1:0] diag_cfg_o,
    output logic [NCH*NIB_W-1:0] drive_cfg_o,
    output logic [1:0]         uvov_dis_o,
    output logic [1:0]         wd_period_o
);
    logic                      commit, wd_bit;
    logic [ADDR_W-1:0]         addr, prev_q;
    logic [NIB_W-1:0]          data, rd_data;
    logic                      wd_q;
    logic [FRAME_W-1:0]        resp;
    logic [NCH-1:0][NIB_W-1:0] flt;
    logic [NCH-1:0]            on_set, status;
    chcfg_t [NCH-1:0]          cfg;

    swbank_shifter u_shift (
        .clk(clk), .rst_n(rst_n), .sclk_i(spi_sclk_i), .cs_n_i(spi_cs_n_i),
        .mosi_i(spi_mosi_i), .resp_i(resp), .miso_o(spi_miso_o),
        .oe_o(spi_miso_oe_o), .commit_o(commit), .wd_o(wd_bit),
        .addr_o(addr), .data_o(data)
    );

    swbank_regs u_regs (
        .clk(clk), .rst_n(rst_n), .commit_i(commit), .addr_i(addr),
        .data_i(data), .rd_addr_i(prev_q), .flt_i(flt),
        .wd_timeout_i(wd_timeout_i), .wd_en_i(wd_en_i),
        .strap_ch2_i(strap_ch2_i), .strap_ch0_i(strap_ch0_i),
        .wake_i(wake_i), .din_i(din_i), .on_o(ch_on_o), .sen_o(sense_en_o),
        .cfg_o(cfg), .uvov_o(uvov_dis_o), .wdper_o(wd_period_o),
        .on_set_o(on_set), .rd_data_o(rd_data)
    );

    swbank_faults u_flt (
        .clk(clk), .rst_n(rst_n), .ot_i(flt_otemp_i), .oh_i(flt_ochi_i),
        .ol_i(flt_oclo_i), .op_i(flt_oload_i), .on_set_i(on_set),
        .din_i(din_i), .flt_o(flt)
    );

    // Previous address and toggle bit advance on an accepted frame
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
            wd_q   <= 1'b0;
        end else if (commit) begin
            prev_q <= addr;
            wd_q   <= wd_bit;
        end
    end

    // Per channel summary status and flattened configuration outputs
    for (genvar ch = 0; ch < NCH; ch++) begin : g_out
        assign status[ch] = |flt[ch];
        assign ocur_cfg_o[ch*NIB_W +: NIB_W]  = cfg[ch].ocur;
        assign diag_cfg_o[ch*NIB_W +: NIB_W]  = cfg[ch].diag;
        assign drive_cfg_o[ch*NIB_W +: NIB_W] = cfg[ch].drive;
    end

    // Response word assembly
    assign resp = {wd_q, uv_flag_i, ov_flag_i, prev_q, status, rd_data};

    // R2: the previous address holds between accepted frames
    a_r2_prev_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(prev_q));
    // R2: an accepted frame's address becomes the previous address
    a_r2_prev_loads: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (prev_q == $past(addr)));
endmodule

// File: tb/tb_swbank_top.sv
// Scoreboard bench: the driver predicts each response word from a model
// and queues it; the monitor rebuilds the serial word and compares.
module tb_swbank_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic spi_sclk = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
    logic spi_miso, spi_oe;
    logic [3:0] ot = '0, oh = '0, ol = '0, op = '0, din = '0;
    logic wake = 0, wd_to = 0, wd_en = 0, s2 = 0, s0 = 0, uv = 0, ov = 0;
    logic [3:0] ch_on, sen;
    logic [15:0] ocur_cfg, diag_cfg, drive_cfg;
    logic [1:0] uvov_dis, wd_per;

    always #2 clk = ~clk;

    swbank_top dut (
        .clk(clk), .rst_n(rst_n), .spi_sclk_i(spi_sclk), .spi_cs_n_i(spi_cs_n),
        .spi_mosi_i(spi_mosi), .spi_miso_o(spi_miso), .spi_miso_oe_o(spi_oe),
        .flt_otemp_i(ot), .flt_ochi_i(oh), .flt_oclo_i(ol), .flt_oload_i(op),
        .din_i(din), .wake_i(wake), .wd_timeout_i(wd_to), .wd_en_i(wd_en),
        .strap_ch2_i(s2), .strap_ch0_i(s0), .uv_flag_i(uv), .ov_flag_i(ov),
        .ch_on_o(ch_on), .sense_en_o(sen), .ocur_cfg_o(ocur_cfg),
        .diag_cfg_o(diag_cfg), .drive_cfg_o(drive_cfg),
        .uvov_dis_o(uvov_dis), .wd_period_o(wd_per)
    );

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    typedef struct { logic [15:0] w; string tag; } exp_t;
    exp_t exp_q[$];

    // Register model
    logic       m_wd = 0;
    logic [4:0] m_prev = '0;
    logic [3:0] m_flt [4] = '{default: '0};
    logic [3:0] m_oc [4] = '{default: '0};
    logic [3:0] m_dg [4] = '{default: '0};
    logic [3:0] m_dr [4] = '{default: '0};
    logic [3:0] m_on = '0, m_sen = '0;
    logic [1:0] m_uvov = '0, m_wdp = '0;

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] mk(input logic wd, input logic [1:0] s,
                                       input logic [2:0] c, input logic [3:0] d);
        return {wd, s, c, 6'b0, d};
    endfunction

    function automatic logic [15:0] exp_word();
        logic [1:0] s;
        logic [2:0] c;
        logic [3:0] d, st;
        s = m_prev[4:3];
        c = m_prev[2:0];
        case (c)
            3'd0: d = m_flt[s];
            3'd1: d = s[0] ? m_sen : m_on;
            3'd2: d = m_oc[s];
            3'd3: d = m_dg[s];
            3'd4: d = m_dr[s];
            3'd5: d = s[0] ? {1'b0, wd_to, m_wdp} : {2'b00, m_uvov};
            3'd6: d = s[0] ? din : {s2, s0, wd_en, wake};
            default: d = 4'h0;
        endcase
        for (int ch = 0; ch < 4; ch++) st[ch] = |m_flt[ch];
        return {m_wd, uv, ov, m_prev, st, d};
    endfunction

    task automatic model_commit(input logic [15:0] f);
        logic [1:0] s;
        logic [3:0] d;
        s = f[14:13];
        d = f[3:0];
        m_wd = f[15];
        m_prev = f[14:10];
        case (f[12:10])
            3'd1: if (s[0]) m_sen = d;
                  else begin
                      m_on = d;
                      for (int ch = 0; ch < 4; ch++) if (d[ch]) m_flt[ch] = '0;
                  end
            3'd2: m_oc[s] = d;
            3'd3: m_dg[s] = d;
            3'd4: m_dr[s] = d;
            3'd5: if (s[0]) m_wdp = d[1:0]; else m_uvov = d[1:0];
            default: ;
        endcase
    endtask

    task automatic xfer(input logic [15:0] tx, input int nbits);
        @(negedge clk) spi_cs_n = 1'b0;
        repeat (3) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            spi_mosi = (i < 16) ? tx[15-i] : 1'b0;
            repeat (2) @(negedge clk);
            spi_sclk = 1'b1;
            repeat (2) @(negedge clk);
            spi_sclk = 1'b0;
            repeat (2) @(negedge clk);
        end
        spi_cs_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    // Driver: predict, queue, send, then update the model
    task automatic frame(input logic [15:0] tx, input string tag);
        exp_t e;
        e.w = exp_word();
        e.tag = tag;
        exp_q.push_back(e);
        xfer(tx, 16);
        model_commit(tx);
    endtask

    task automatic set_din(input logic [3:0] v);
        for (int ch = 0; ch < 4; ch++) if (v[ch] && !din[ch]) m_flt[ch] = '0;
        @(negedge clk) din = v;
        repeat (3) @(negedge clk);
    endtask

    task automatic pulse_flt(input int ch, input logic [3:0] nib);
        @(negedge clk);
        ot[ch] = nib[3]; oh[ch] = nib[2]; ol[ch] = nib[1]; op[ch] = nib[0];
        @(negedge clk);
        ot = '0; oh = '0; ol = '0; op = '0;
        m_flt[ch] = m_flt[ch] | nib;
        repeat (2) @(negedge clk);
    endtask

    // Monitor: rebuild each serial response and compare with the queue
    initial begin
        forever begin
            logic [15:0] w;
            int nb;
            bit oe_bad;
            @(negedge spi_cs_n);
            w = '0; nb = 0; oe_bad = 0;
            while (spi_cs_n == 1'b0) begin
                @(posedge spi_sclk or posedge spi_cs_n);
                if (!spi_cs_n) begin
                    if (spi_oe !== 1'b1) oe_bad = 1;
                    w = {w[14:0], spi_miso};
                    nb++;
                end
            end
            if (nb == 16) begin
                if (exp_q.size() == 0) chk(32'd1, 32'd0, "R2 unexpected response");
                else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk({16'h0, w}, {16'h0, e.w}, e.tag);
                    chk({31'h0, oe_bad}, 32'd0, "R11 SO enabled during frame");
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R12 / R11: idle state after reset
        chk({31'h0, spi_oe}, 32'd0, "R11 SO disabled while CS_n high");
        chk({24'h0, ch_on, sen}, 32'd0, "R12 on/sense reset");
        chk({ocur_cfg, diag_cfg}, 32'd0, "R12 channel config reset");
        chk({16'h0, drive_cfg}, 32'd0, "R12 drive config reset");
        chk({28'h0, uvov_dis, wd_per}, 32'd0, "R12 global reset");
        frame(mk(0, 2'b00, 3'd7, 4'h0), "R12 R2 first response after reset");

        // R1: supply flags and toggle bit
        uv = 1'b1;
        frame(mk(1, 2'b10, 3'd1, 4'b1010), "R1 flags in response");
        uv = 1'b0; ov = 1'b1;
        // R5: switch-on / sense enable; sel[1] ignored
        frame(mk(0, 2'b01, 3'd1, 4'b0110), "R5 switch-on readback, sel1 ignored");
        frame(mk(0, 2'b11, 3'd7, 4'h0), "R5 sense enable readback");
        chk({28'h0, ch_on}, 32'hA, "R5 switch-on port");
        chk({28'h0, sen}, 32'h6, "R5 sense port keeps own value");
        ov = 1'b0;

        // R6: per-channel nibbles, each write reads back on the next frame
        for (int ch = 0; ch < 4; ch++) begin
            frame(mk(0, 2'(ch), 3'd2, 4'(ch * 3 + 2)), "R6 overcurrent chain");
            frame(mk(0, 2'(ch), 3'd3, 4'(15 - ch * 2)), "R6 diagnostic chain");
            frame(mk(0, 2'(ch), 3'd4, 4'(ch * 5 + 1)), "R6 drive chain");
        end
        frame(mk(0, 2'b01, 3'd2, 4'h9), "R6 drive readback");
        frame(mk(0, 2'b01, 3'd7, 4'h0), "R6 ch1 overwrite readback");
        for (int ch = 0; ch < 4; ch++) begin
            chk({28'h0, ocur_cfg[ch*4 +: 4]}, {28'h0, m_oc[ch]}, "R6 overcurrent port");
            chk({28'h0, diag_cfg[ch*4 +: 4]}, {28'h0, m_dg[ch]}, "R6 diagnostic port");
            chk({28'h0, drive_cfg[ch*4 +: 4]}, {28'h0, m_dr[ch]}, "R6 drive port");
        end

        // R7 / R8: global bits
        frame(mk(0, 2'b10, 3'd5, 4'hF), "R7 write supply disables");
        frame(mk(0, 2'b01, 3'd5, 4'hE), "R7 supply disables read as 0011");
        wd_to = 1'b1;
        frame(mk(0, 2'b00, 3'd7, 4'h0), "R8 watchdog period and timeout");
        chk({28'h0, uvov_dis, wd_per}, 32'hE, "R7 R8 global ports");

        // R9: status reads and read-only codes
        s2 = 1'b1; s0 = 1'b0; wd_en = 1'b1; wake = 1'b1;
        set_din(4'b1001);
        frame(mk(1, 2'b00, 3'd6, 4'hF), "R9 before strap read");
        frame(mk(0, 2'b11, 3'd6, 4'h5), "R9 strap, enable and wake");
        frame(mk(0, 2'b01, 3'd0, 4'hF), "R9 live direct pins");
        frame(mk(0, 2'b00, 3'd7, 4'hF), "R4 R9 code 000 write ignored");
        frame(mk(0, 2'b00, 3'd0, 4'h0), "R9 code 111 reads zero");
        chk({28'h0, ch_on}, {28'h0, m_on}, "R9 read-only codes keep switch-on");
        chk({ocur_cfg, diag_cfg}, {m_oc[3], m_oc[2], m_oc[1], m_oc[0],
                                   m_dg[3], m_dg[2], m_dg[1], m_dg[0]}, "R9 config unchanged");

        // R10 / R4: fault latching and both clear paths
        pulse_flt(2, 4'b1001);
        pulse_flt(1, 4'b0010);
        pulse_flt(3, 4'b0100);
        frame(mk(0, 2'b10, 3'd0, 4'h0), "R10 status after fault pulses");
        frame(mk(0, 2'b01, 3'd0, 4'h0), "R4 fault nibble channel 2");
        frame(mk(0, 2'b11, 3'd0, 4'h0), "R4 fault nibble channel 1");
        frame(mk(0, 2'b00, 3'd1, 4'b0100), "R4 fault nibble channel 3");
        frame(mk(0, 2'b10, 3'd0, 4'h0), "R10 SPI switch-on clears only channel 2");
        set_din(4'b1011);
        frame(mk(0, 2'b01, 3'd0, 4'h0), "R10 pin edge clears channel 1");
        chk({28'h0, ch_on}, 32'h4, "R10 switch-on port");

        // R3: wrong frame lengths are ignored
        xfer(mk(1, 2'b00, 3'd1, 4'hF), 8);
        chk({28'h0, ch_on}, 32'h4, "R3 short frame ignored at port");
        frame(mk(0, 2'b11, 3'd7, 4'h0), "R3 short frame leaves previous address");
        xfer(mk(1, 2'b00, 3'd1, 4'hF), 17);
        chk({28'h0, ch_on}, 32'h4, "R3 long frame ignored at port");
        frame(mk(0, 2'b00, 3'd7, 4'h0), "R3 long frame leaves previous address");
        chk({31'h0, spi_oe}, 32'd0, "R11 SO disabled after frame");

        repeat (20) @(negedge clk);
        chk(exp_q.size(), 32'd0, "R2 all responses seen");
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule